// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register file for a development board. A processor reaches it through a plain 32-bit word bus. It uses the register file to light an 8-LED bar, to write an eight-character ASCII display, to request a system reset, to set a general-purpose output byte, and to bit-bang an I2C line towards a serial EEPROM. Only the low 20 address bits select a register. Read data and the error flag are registered, so they appear in the cycle after the access.

The display can be loaded in two ways. A single write of a 32-bit word turns the value into eight uppercase hexadecimal characters. Eight character registers, spaced 8 bytes apart from offset 0x418, each load one position. Position 0 is the leftmost character and occupies bits [7:0] of `disp_chars`. Position i occupies bits [8i+7:8i].

Register offsets (20-bit): switches 0x00000, LED bar 0x00010, hex word 0x00410, characters 0x00418 + 8·i (i = 0..7), soft reset 0x00500, general output 0x00A00, I2C input 0x00B00, I2C output enable 0x00B08, I2C output 0x00B10, I2C select 0x00B18.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits [19:0] are decoded. An access whose upper address bits are set behaves exactly like one to the same 20-bit offset.
- R2: A write to the LED bar register keeps wdata[7:0] on `led_bar`. Bit 7 is the leftmost LED. The register reads back as that byte, zero-extended.
- R3: A write to the hex word register sets all eight characters in the cycle after the write. Position 0 takes the most significant nibble. Nibbles 0–9 map to 0x30–0x39 and nibbles A–F map to 0x41–0x46.
- R4: A write to offset 0x418 + 8·i stores wdata[7:0] in character position i. The other positions are left unchanged.
- R5: The switch register always reads zero. Writes to it are ignored and raise no error.
- R6: A write to the soft reset register produces `reset_req` high for exactly one cycle, the cycle after the write.
- R7: The output-enable register keeps 2 bits, the select register keeps 1 bit and the general output register keeps 8 bits, each taken from the low bits of wdata. Each reads back zero-extended.
- R8: In the I2C output register, wdata bit 1 drives `i2c_scl_drv` and bit 0 drives `i2c_sda_drv`. The register reads back as {SCL, SDA} in bits [1:0].
- R9: A read of the I2C input register returns `eeprom_sda_in` live in bit 0, the driven SCL in bit 1, and zero above.
- R10: After reset every character is 0x20 (space). All other outputs and registers are zero.
- R11: An access to an undefined offset reads zero and changes no state. It raises `bus_err` for one cycle, the cycle after the access.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled and holds until the next read. Reads of write-only registers return zero without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address; low 20 bits decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle pulse for an undefined offset |
| led_bar | output | 8 | LED bar, bit 7 leftmost |
| disp_chars | output | 64 | Eight display characters, position i at [8i+7:8i] |
| reset_req | output | 1 | One-cycle system reset request |
| gp_out | output | 8 | General-purpose output byte |
| i2c_scl_drv | output | 1 | I2C clock drive value |
| i2c_sda_drv | output | 1 | I2C data drive value |
| i2c_oe | output | 2 | I2C output enables |
| i2c_sel | output | 1 | I2C select bit |
| eeprom_sda_in | input | 1 | Live SDA level from the EEPROM |

## Verification
The bench targets the hex word conversion with mixed digits and letters. A design off by seven in the letter range would show punctuation instead of A–F. A reversed nibble order would mirror the string. The bench writes to offsets inside the character window that are not aligned to 8 and to the offset just past it. A loose decode would corrupt a character instead of raising `bus_err`. The bench accesses registers with high address bits set and toggles the live SDA input between reads. A full-width decode would miss the alias, and a stored SDA bit would return a stale value.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  localparam int unsigned OFF_SWITCH  = 32'h0_0000;
  localparam int unsigned OFF_LED     = 32'h0_0010;
  localparam int unsigned OFF_WORD    = 32'h0_0410;
  localparam int unsigned OFF_CHAR0   = 32'h0_0418;
  localparam int unsigned CHAR_SH     = 3;            // 8-byte stride
  localparam int unsigned OFF_SOFTRES = 32'h0_0500;
  localparam int unsigned OFF_GPOUT   = 32'h0_0A00;
  localparam int unsigned OFF_I2CIN   = 32'h0_0B00;
  localparam int unsigned OFF_I2COE   = 32'h0_0B08;
  localparam int unsigned OFF_I2COUT  = 32'h0_0B10;
  localparam int unsigned OFF_I2CSEL  = 32'h0_0B18;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SWITCH, SEL_LED, SEL_WORD, SEL_CHAR, SEL_SOFTRES,
    SEL_GPOUT, SEL_I2CIN, SEL_I2COE, SEL_I2COUT, SEL_I2CSEL
  } reg_sel_e;

  // One nibble to an uppercase ASCII hex digit.
  function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
    logic [7:0] wide;
    wide = {4'h0, n};
    return (n < 4'd10) ? (8'h30 + wide) : (8'h37 + wide);
  endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 20,
  parameter int NCHARS = 8,
  localparam int IDX_W = $clog2(NCHARS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  char_idx
);
  localparam int unsigned CHAR_END = OFF_CHAR0 + (NCHARS << CHAR_SH);

  logic [31:0] off32;
  logic        unused_hi;
  logic [31:0] char_rel;

  assign off32     = 32'(addr[OFFS_W-1:0]);
  assign unused_hi = ^addr[ADDR_W-1:OFFS_W];
  assign char_rel  = off32 - OFF_CHAR0;
  assign char_idx  = IDX_W'(char_rel >> CHAR_SH);

  always_comb begin
    sel = SEL_NONE;
    if (off32 >= OFF_CHAR0 && off32 < CHAR_END && off32[CHAR_SH-1:0] == '0)
      sel = SEL_CHAR;
    else begin
      case (off32)
        OFF_SWITCH:  sel = SEL_SWITCH;
        OFF_LED:     sel = SEL_LED;
        OFF_WORD:    sel = SEL_WORD;
        OFF_SOFTRES: sel = SEL_SOFTRES;
        OFF_GPOUT:   sel = SEL_GPOUT;
        OFF_I2CIN:   sel = SEL_I2CIN;
        OFF_I2COE:   sel = SEL_I2COE;
        OFF_I2COUT:  sel = SEL_I2COUT;
        OFF_I2CSEL:  sel = SEL_I2CSEL;
        default:     sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/bcr_display.sv
module bcr_display
  import bcr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NCHARS = DATA_W / 4,
  localparam int IDX_W  = $clog2(NCHARS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_we,
  input  logic [DATA_W-1:0]   word_data,
  input  logic                char_we,
  input  logic [IDX_W-1:0]    char_idx,
  input  logic [7:0]          char_data,
  output logic [8*NCHARS-1:0] chars
);
  logic [7:0] ch_q [NCHARS];

  for (genvar i = 0; i < NCHARS; i++) begin : g_char
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ch_q[i] <= 8'h20;
      else if (word_we)
        ch_q[i] <= nib_to_ascii(word_data[DATA_W-1-4*i -: 4]);
      else if (char_we && char_idx == IDX_W'(i))
        ch_q[i] <= char_data;
    end
    assign chars[8*i +: 8] = ch_q[i];
  end

  // R11/R4: the buffer moves only on a display write
  p_disp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_we || char_we) |=> $stable(chars));
  // R3: a leading nibble of A shows as the letter A in position 0
  p_word_letter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && word_data[DATA_W-1 -: 4] == 4'hA) |=> chars[7:0] == 8'h41);
endmodule

// File: rtl/bcr_io_regs.sv
module bcr_io_regs #(
  parameter int LED_W = 8,
  parameter int GP_W  = 8,
  parameter int OE_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             led_we,
  input  logic             gp_we,
  input  logic             oe_we,
  input  logic             sel_we,
  input  logic             out_we,
  input  logic             softres_we,
  input  logic [7:0]       wbyte,
  output logic [LED_W-1:0] led,
  output logic [GP_W-1:0]  gp,
  output logic [OE_W-1:0]  oe,
  output logic             sel,
  output logic             scl,
  output logic             sda,
  output logic             reset_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led <= '0; gp <= '0; oe <= '0; sel <= 1'b0;
      scl <= 1'b0; sda <= 1'b0; reset_req <= 1'b0;
    end else begin
      reset_req <= softres_we;
      if (led_we) led <= wbyte[LED_W-1:0];
      if (gp_we)  gp  <= wbyte[GP_W-1:0];
      if (oe_we)  oe  <= wbyte[OE_W-1:0];
      if (sel_we) sel <= wbyte[0];
      if (out_we) begin
        scl <= wbyte[1];
        sda <= wbyte[0];
      end
    end
  end

  p_rstreq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(softres_we));
  p_oe_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_we |=> $stable(oe));
  p_led_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |=> led == $past(wbyte[LED_W-1:0]));
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 20,
  localparam int NCHARS = DATA_W / 4,
  localparam int IDX_W  = $clog2(NCHARS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic [7:0]          led_bar,
  output logic [8*NCHARS-1:0] disp_chars,
  output logic                reset_req,
  output logic [7:0]          gp_out,
  output logic                i2c_scl_drv,
  output logic                i2c_sda_drv,
  output logic [1:0]          i2c_oe,
  output logic                i2c_sel,
  input  logic                eeprom_sda_in
);
  reg_sel_e          sel;
  logic [IDX_W-1:0]  char_idx;
  logic              bad_acc;
  logic [DATA_W-1:0] rd_mux;

  bcr_decode #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .NCHARS(NCHARS)) i_dec (
    .addr(bus_addr), .sel(sel), .char_idx(char_idx));

  bcr_display #(.DATA_W(DATA_W)) i_disp (
    .clk(clk), .rst_n(rst_n),
    .word_we(bus_wr && sel == SEL_WORD), .word_data(bus_wdata),
    .char_we(bus_wr && sel == SEL_CHAR), .char_idx(char_idx),
    .char_data(bus_wdata[7:0]), .chars(disp_chars));

  bcr_io_regs #(.LED_W(8), .GP_W(8), .OE_W(2)) i_io (
    .clk(clk), .rst_n(rst_n),
    .led_we(bus_wr && sel == SEL_LED),
    .gp_we(bus_wr && sel == SEL_GPOUT),
    .oe_we(bus_wr && sel == SEL_I2COE),
    .sel_we(bus_wr && sel == SEL_I2CSEL),
    .out_we(bus_wr && sel == SEL_I2COUT),
    .softres_we(bus_wr && sel == SEL_SOFTRES),
    .wbyte(bus_wdata[7:0]),
    .led(led_bar), .gp(gp_out), .oe(i2c_oe), .sel(i2c_sel),
    .scl(i2c_scl_drv), .sda(i2c_sda_drv), .reset_req(reset_req));

  assign bad_acc = (bus_wr || bus_rd) && sel == SEL_NONE;

  always_comb begin
    case (sel)
      SEL_LED:    rd_mux = DATA_W'(led_bar);
      SEL_GPOUT:  rd_mux = DATA_W'(gp_out);
      SEL_I2COE:  rd_mux = DATA_W'(i2c_oe);
      SEL_I2CSEL: rd_mux = DATA_W'(i2c_sel);
      SEL_I2COUT: rd_mux = DATA_W'({i2c_scl_drv, i2c_sda_drv});
      SEL_I2CIN:  rd_mux = DATA_W'({i2c_scl_drv, eeprom_sda_in});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad_acc;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));
  p_err_rdzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && $past(bus_rd)) |-> bus_rdata == '0);
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_board_ctl_regs.sv
`timescale 1ns/1ps
module test_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  led_bar, gp_out;
  logic [63:0] disp_chars;
  logic        reset_req, i2c_scl_drv, i2c_sda_drv, i2c_sel;
  logic [1:0]  i2c_oe;
  logic        eeprom_sda_in = 1'b0;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic [63:0] exp_disp;

  always #4 clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata, .bus_err,
    .led_bar, .disp_chars, .reset_req, .gp_out, .i2c_scl_drv, .i2c_sda_drv,
    .i2c_oe, .i2c_sel, .eeprom_sda_in);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: the scoreboard compares read data one edge after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && rst_n) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read result act=%h exp=none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(64'(bus_rdata), 64'(e), t);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    string digits = "0123456789ABCDEF";
    logic [63:0] r;
    for (int i = 0; i < 8; i++)
      r[8*i +: 8] = digits[int'((v >> (28 - 4*i)) & 32'hF)];
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    exp_disp = {8{8'h20}};
    chk(disp_chars, exp_disp, "R10 display spaces");
    chk(64'({led_bar, gp_out, i2c_oe, i2c_sel, i2c_scl_drv, i2c_sda_drv, reset_req, bus_err}),
        64'd0, "R10 outputs zero");
    // R5 switches
    rd(32'h0_0000, 32'h0, "R5 switch reads zero");
    wr(32'h0_0000, 32'hFFFF_FFFF);
    chk(64'(bus_err), 64'd0, "R5 switch write no error");
    rd(32'h0_0000, 32'h0, "R5 switch still zero");
    // R2 LED bar
    wr(32'h0_0010, 32'h1234_5AC3);
    chk(64'(led_bar), 64'hC3, "R2 led low byte");
    rd(32'h0_0010, 32'hC3, "R2 led readback");
    // R12 hold
    repeat (2) @(negedge clk);
    chk(64'(bus_rdata), 64'hC3, "R12 rdata holds");
    rd(32'h0_0410, 32'h0, "R12 write-only reads zero");
    chk(64'(bus_err), 64'd0, "R12 write-only no error");
    // R1 alias
    wr(32'hFFF0_0010, 32'h7E);
    chk(64'(led_bar), 64'h7E, "R1 aliased write");
    rd(32'hABC0_0010, 32'h7E, "R1 aliased read");
    // R3 hex word
    wr(32'h0_0410, 32'h9A5F_03E7);
    exp_disp = hex_text(32'h9A5F_03E7);
    chk(disp_chars, exp_disp, "R3 mixed digits");
    wr(32'h0_0410, 32'h0);
    exp_disp = hex_text(32'h0);
    chk(disp_chars, exp_disp, "R3 all zero");
    wr(32'h0_0410, 32'hFEDC_BA98);
    exp_disp = hex_text(32'hFEDC_BA98);
    chk(disp_chars, exp_disp, "R3 letters");
    // R4 per character
    wr(32'h0_0418, 32'h141);
    exp_disp[7:0] = 8'h41;
    chk(disp_chars, exp_disp, "R4 position 0");
    wr(32'h0_0450, 32'h5A);
    exp_disp[63:56] = 8'h5A;
    chk(disp_chars, exp_disp, "R4 position 7");
    wr(32'h0_0430, 32'h2A);
    exp_disp[31:24] = 8'h2A;
    chk(disp_chars, exp_disp, "R4 position 3");
    // R11 undefined offsets
    wr(32'h0_041C, 32'h77);
    chk(64'(bus_err), 64'd1, "R11 misaligned char error");
    chk(disp_chars, exp_disp, "R11 display untouched");
    @(negedge clk);
    chk(64'(bus_err), 64'd0, "R11 error one cycle");
    wr(32'h0_0458, 32'h77);
    chk(64'(bus_err), 64'd1, "R11 past window error");
    chk(disp_chars, exp_disp, "R11 display untouched 2");
    rd(32'h0_0004, 32'h0, "R11 undefined read zero");
    chk(64'(bus_err), 64'd1, "R11 read error");
    // R6 soft reset
    wr(32'h0_0500, 32'h1);
    chk(64'(reset_req), 64'd1, "R6 reset pulse");
    @(negedge clk);
    chk(64'(reset_req), 64'd0, "R6 reset one cycle");
    chk(64'(led_bar), 64'h7E, "R6 led kept");
    // R7 small registers
    wr(32'h0_0A00, 32'h1A5);
    chk(64'(gp_out), 64'hA5, "R7 gp out");
    rd(32'h0_0A00, 32'hA5, "R7 gp readback");
    wr(32'h0_0B08, 32'hFF);
    chk(64'(i2c_oe), 64'h3, "R7 oe two bits");
    rd(32'h0_0B08, 32'h3, "R7 oe readback");
    wr(32'h0_0B18, 32'h6);
    chk(64'(i2c_sel), 64'd0, "R7 sel bit0 only");
    wr(32'h0_0B18, 32'h7);
    chk(64'(i2c_sel), 64'd1, "R7 sel set");
    // R8 I2C output
    wr(32'h0_0B10, 32'h2);
    chk(64'({i2c_scl_drv, i2c_sda_drv}), 64'b10, "R8 scl high");
    wr(32'h0_0B10, 32'h1);
    chk(64'({i2c_scl_drv, i2c_sda_drv}), 64'b01, "R8 sda high");
    rd(32'h0_0B10, 32'h1, "R8 readback");
    // R9 I2C input
    wr(32'h0_0B10, 32'h3);
    eeprom_sda_in = 1'b0;
    rd(32'h0_0B00, 32'h2, "R9 sda low");
    eeprom_sda_in = 1'b1;
    rd(32'h0_0B00, 32'h3, "R9 sda high");
    wr(32'h0_0B10, 32'h0);
    rd(32'h0_0B00, 32'h1, "R9 scl low sda high");
    @(negedge clk);
    chk(64'(exp_q.size()), 64'd0, "R12 all reads returned");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule